// File: doc/BRIEF.md
# Multichannel PCM highway port

This block joins four voice channels to one shared serial time-division highway. All channels share a single transmit line and a single receive line. Each channel has its own transmit sync pin and its own receive sync pin. The external timing source pulses a channel's sync, and the block drives that channel's 8-bit companded code onto the transmit line, most significant bit first. In the same way, it collects the channel's code from the receive line during the slot its receive sync marks. No register sets the position on the highway: the sync pins alone place each channel. This lets the same block work at any bit rate from 256 kHz to 8.192 MHz, which is up to 128 slots per frame.

All logic runs on the PCM bit clock. Bits are launched on rising edges. Syncs and receive data are sampled on falling edges. One mode input chooses short framing, where a sync is a pulse one bit clock wide, or long framing, where the sync is a level held high across the slot. The transmit line is driven only while a slot is active. At other times it floats, and an output enable shows when it is driven. The block handles the 8-bit codes as opaque bytes, so the same slots carry either companding law.

Top module: `pcm_highway_port`

## Requirements
- R1: While reset is asserted, and just after it is released, `tx_oe`, `tx_collide` and every `rx_valid` bit are low, and `rx_words` is all zeros.
- R2: Suppose a channel's transmit sync is seen high on a falling edge and starts a slot. On each of the next eight rising edges the block drives one bit of that channel's word, taken from `tx_words[8n+7:8n]`, starting with bit 7 and ending with bit 0.
- R3: `tx_oe` is high only while at least one transmit slot is in its eight bit periods. It falls on the rising edge after the last bit, and `pcm_tx` is high impedance whenever `tx_oe` is low.
- R4: With `long_fs`=0 (short framing), every falling edge that samples a sync high starts the slot again from bit 7. A sync held high for two clocks therefore sends bit 7 twice and then bits 6 down to 0.
- R5: With `long_fs`=1 (long framing), only a low-to-high change of the sampled sync starts a slot. A sync held high beyond eight bit periods does not start a second slot.
- R6: In a receive slot, `pcm_rx` is sampled on the eight falling edges that follow the slot's eight rising edges, most significant bit first. The byte is placed in `rx_words[8n+7:8n]`.
- R7: When channel n captures its eighth bit, `rx_valid[n]` goes high on that falling edge for exactly one clock. `rx_words` is updated on the same edge, and the other channels' bytes stay unchanged.
- R8: If more than one channel's transmit slot is active, the lowest-numbered active channel drives `pcm_tx`, and `tx_collide` is high for every bit period in which two or more slots are active.
- R9: When no receive slot is active, activity on `pcm_rx` raises no `rx_valid` bit and leaves `rx_words` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_fs | input | 1 | 1 = long (level) framing, 0 = short (pulse) framing |
| fs_tx | input | N_CH | Transmit sync, one bit per channel |
| fs_rx | input | N_CH | Receive sync, one bit per channel |
| tx_words | input | N_CH*SLOT_W | Outgoing code per channel, channel n at bits [8n+7:8n] |
| pcm_rx | input | 1 | Shared receive data line |
| pcm_tx | output | 1 | Shared transmit data line, high impedance when idle |
| tx_oe | output | 1 | High while `pcm_tx` is driven |
| tx_collide | output | 1 | High while two or more transmit slots overlap |
| rx_words | output | N_CH*SLOT_W | Last captured code per channel |
| rx_valid | output | N_CH | One-clock strobe per channel after its eighth received bit |

## Verification
The bench sweeps every channel through 32 different byte pairs in both framing modes. It checks every transmit bit and every received byte, so a design that shifted LSB first, started one edge late, or left a gap before the first bit would fail at once. Four corner cases are tested on their own. A short sync held for two clocks must restart the slot; a design that ignored the second high sample would send bit 6 where bit 7 is expected. A long sync held past the slot must not retrigger; a level-triggered design would drive the line again. Two transmit syncs are fired together to confirm that the lower channel wins and the collide flag goes up. A receive line that toggles with no sync active must raise no strobe and change no stored byte.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;

   typedef enum logic {
      FS_SHORT = 1'b0,
      FS_LONG  = 1'b1
   } fs_mode_e;

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
   import pcm_hwy_pkg::*;
#(
   parameter int SLOT_W = 8,
   localparam int CW = $clog2(SLOT_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  fs_mode_e      mode,
   input  logic          fs,
   output logic [CW-1:0] pos
);

   logic fs_smp;
   logic fs_prev;
   logic begin_slot;

   // sync is sampled on the falling edge of the bit clock
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_smp  <= 1'b0;
         fs_prev <= 1'b0;
      end else begin
         fs_smp  <= fs;
         fs_prev <= fs_smp;
      end
   end

   generate
      always_comb begin
         if (mode == FS_LONG) begin_slot = fs_smp & ~fs_prev;
         else                 begin_slot = fs_smp;
      end
   endgenerate

   // pos = 0 idle, 1..SLOT_W = bit period in progress
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pos <= '0;
      else if (begin_slot)            pos <= CW'(1);
      else if (pos == CW'(SLOT_W))    pos <= '0;
      else if (pos != '0)             pos <= pos + CW'(1);
   end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
   parameter int SLOT_W = 8,
   localparam int CW = $clog2(SLOT_W + 1),
   localparam int IW = $clog2(SLOT_W)
) (
   input  logic [CW-1:0]     pos,
   input  logic [SLOT_W-1:0] word,
   output logic              active,
   output logic              bit_out
);

   logic [IW-1:0] sel;

   assign active = (pos != '0);

   always_comb begin
      sel     = IW'(SLOT_W - int'(pos));
      bit_out = active ? word[sel] : 1'b0;
   end

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
   parameter int SLOT_W = 8,
   localparam int CW = $clog2(SLOT_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     pos,
   input  logic              din,
   output logic [SLOT_W-1:0] word,
   output logic              valid
);

   logic [SLOT_W-1:0] shreg;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (pos != '0) shreg <= {shreg[SLOT_W-2:0], din};
         if (pos == CW'(SLOT_W)) begin
            word  <= {shreg[SLOT_W-2:0], din};
            valid <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pcm_highway_port.sv
module pcm_highway_port
   import pcm_hwy_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int SLOT_W = 8,
   localparam int CW    = $clog2(SLOT_W + 1),
   localparam int BUS_W = N_CH * SLOT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             long_fs,
   input  logic [N_CH-1:0]  fs_tx,
   input  logic [N_CH-1:0]  fs_rx,
   input  logic [BUS_W-1:0] tx_words,
   input  logic             pcm_rx,
   output logic             pcm_tx,
   output logic             tx_oe,
   output logic             tx_collide,
   output logic [BUS_W-1:0] rx_words,
   output logic [N_CH-1:0]  rx_valid
);

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("pcm_highway_port: N_CH must be at least 1");
      end
      if (SLOT_W < 2) begin : g_bad_slot
         $error("pcm_highway_port: SLOT_W must be at least 2");
      end
   endgenerate

   fs_mode_e          mode;
   logic [N_CH-1:0]   tx_act;
   logic [N_CH-1:0]   tx_bit;
   logic              tx_data;

   assign mode = long_fs ? FS_LONG : FS_SHORT;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      logic [CW-1:0] tx_pos;
      logic [CW-1:0] rx_pos;

      pcm_slot_timer #(.SLOT_W(SLOT_W)) u_tx_tmr (
         .clk(clk), .rst_n(rst_n), .mode(mode), .fs(fs_tx[ch]), .pos(tx_pos)
      );

      pcm_tx_lane #(.SLOT_W(SLOT_W)) u_tx_lane (
         .pos(tx_pos), .word(tx_words[ch*SLOT_W +: SLOT_W]),
         .active(tx_act[ch]), .bit_out(tx_bit[ch])
      );

      pcm_slot_timer #(.SLOT_W(SLOT_W)) u_rx_tmr (
         .clk(clk), .rst_n(rst_n), .mode(mode), .fs(fs_rx[ch]), .pos(rx_pos)
      );

      pcm_rx_lane #(.SLOT_W(SLOT_W)) u_rx_lane (
         .clk(clk), .rst_n(rst_n), .pos(rx_pos), .din(pcm_rx),
         .word(rx_words[ch*SLOT_W +: SLOT_W]), .valid(rx_valid[ch])
      );
   end

   // lowest-numbered active channel owns the line
   always_comb begin
      tx_data = 1'b0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (tx_act[i]) tx_data = tx_bit[i];
      end
   end

   assign tx_oe      = |tx_act;
   assign tx_collide = ($countones(tx_act) > 1);
   assign pcm_tx     = tx_oe ? tx_data : 1'bz;

endmodule

// File: rtl/pcm_highway_port_chk.sv
module pcm_highway_port_chk #(
   parameter int N_CH   = 4,
   parameter int SLOT_W = 8,
   localparam int BUS_W = N_CH * SLOT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_oe,
   input logic             tx_collide,
   input logic [BUS_W-1:0] rx_words,
   input logic [N_CH-1:0]  rx_valid
);

   // R1: outputs quiet while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!tx_oe && !tx_collide && rx_valid == '0);
      end
   end

   // R7: a valid strobe never lasts two clocks
   p_valid_single_r7: assert property (@(negedge clk) disable iff (!rst_n)
      (rx_valid & $past(rx_valid)) == '0);

   // R7: stored bytes change only together with a strobe
   p_words_hold_r7: assert property (@(negedge clk) disable iff (!rst_n)
      !$stable(rx_words) |-> (rx_valid != '0));

   // R8: a collision implies the line is being driven
   p_collide_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_collide |-> tx_oe);

endmodule

bind pcm_highway_port pcm_highway_port_chk #(.N_CH(N_CH), .SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_oe(tx_oe), .tx_collide(tx_collide),
   .rx_words(rx_words), .rx_valid(rx_valid)
);

// File: tb/test_pcm_highway_port.sv
module test_pcm_highway_port;

   localparam int N_CH = 4;
   localparam int W    = 8;
   localparam int BW   = N_CH * W;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          long_fs;
   logic [N_CH-1:0] fs_tx, fs_rx;
   logic [BW-1:0] tx_words;
   logic          pcm_rx;
   wire           pcm_tx;
   logic          tx_oe, tx_collide;
   logic [BW-1:0] rx_words;
   logic [N_CH-1:0] rx_valid;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_rx [N_CH];

   always #10 clk = ~clk;

   pcm_highway_port #(.N_CH(N_CH), .SLOT_W(W)) i_pcm_highway_port (
      .clk(clk), .rst_n(rst_n), .long_fs(long_fs), .fs_tx(fs_tx), .fs_rx(fs_rx),
      .tx_words(tx_words), .pcm_rx(pcm_rx), .pcm_tx(pcm_tx), .tx_oe(tx_oe),
      .tx_collide(tx_collide), .rx_words(rx_words), .rx_valid(rx_valid)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] packed_rx();
      logic [BW-1:0] v;
      for (int i = 0; i < N_CH; i++) v[i*W +: W] = exp_rx[i];
      return v;
   endfunction

   task automatic do_slot(input int ch, input logic [W-1:0] tv, input logic [W-1:0] rv,
                          input bit lng);
      @(posedge clk); #2;
      long_fs = lng;
      tx_words[ch*W +: W] = tv;
      fs_tx[ch] = 1'b1;
      fs_rx[ch] = 1'b1;
      for (int k = 1; k <= W; k++) begin
         @(posedge clk); #1;
         if ((!lng && k == 1) || (lng && k == W)) begin
            fs_tx[ch] = 1'b0;
            fs_rx[ch] = 1'b0;
         end
         pcm_rx = rv[W-k];
         #4;
         check(tx_oe === 1'b1 && pcm_tx === tv[W-k],
               lng ? "R2 R5 long-frame tx bit" : "R2 short-frame tx bit",
               {tx_oe, pcm_tx}, {1'b1, tv[W-k]});
         @(negedge clk); #5;
         if (k < W) begin
            check(rx_valid == '0, "R7 no strobe before eighth bit", rx_valid, 0);
         end else begin
            exp_rx[ch] = rv;
            check(rx_valid == N_CH'(1 << ch), "R7 strobe after eighth bit", rx_valid, 1 << ch);
            check(rx_words == packed_rx(), "R6 captured byte", rx_words, packed_rx());
         end
      end
      @(posedge clk); #5;
      check(!tx_oe, "R3 line released after slot", tx_oe, 0);
      @(negedge clk); #5;
      check(rx_valid == '0, "R7 strobe lasts one clock", rx_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R2 actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] tv;
      for (int i = 0; i < N_CH; i++) exp_rx[i] = '0;
      rst_n = 1'b1; long_fs = 1'b0; fs_tx = '0; fs_rx = '0;
      tx_words = '0; pcm_rx = 1'b0;
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      check(!tx_oe && !tx_collide && rx_valid == '0 && rx_words == '0,
            "R1 outputs during reset", {tx_oe, tx_collide, rx_valid}, 0);
      @(negedge clk); #2 rst_n = 1'b1;
      @(posedge clk); #5;
      check(!tx_oe && !tx_collide && rx_valid == '0 && rx_words == '0,
            "R1 outputs after release", {tx_oe, tx_collide, rx_valid}, 0);

      // R9: receive line toggles with no sync active
      for (int i = 0; i < 16; i++) begin
         @(posedge clk); #1 pcm_rx = i[0] ^ i[2];
         @(negedge clk); #5;
         check(rx_valid == '0 && rx_words == packed_rx(), "R9 idle line ignored",
               rx_words, packed_rx());
      end

      // R8: channels 0 and 2 fire together
      @(posedge clk); #2;
      long_fs = 1'b0;
      tx_words[0 +: W]   = 8'hC5;
      tx_words[2*W +: W] = 8'h3A;
      fs_tx[0] = 1'b1; fs_tx[2] = 1'b1;
      for (int k = 1; k <= W; k++) begin
         @(posedge clk); #1;
         if (k == 1) begin fs_tx[0] = 1'b0; fs_tx[2] = 1'b0; end
         #4;
         tv = 8'hC5;
         check(tx_oe === 1'b1 && pcm_tx === tv[W-k], "R8 lowest channel owns line",
               pcm_tx, tv[W-k]);
         check(tx_collide === 1'b1, "R8 collide flag raised", tx_collide, 1);
      end
      @(posedge clk); #5;
      check(!tx_collide && !tx_oe, "R8 collide cleared", {tx_collide, tx_oe}, 0);

      // R4: short sync held two clocks restarts the slot
      @(posedge clk); #2;
      tv = 8'h6B;
      tx_words[3*W +: W] = tv;
      fs_tx[3] = 1'b1;
      for (int j = 1; j <= W + 1; j++) begin
         @(posedge clk); #1;
         if (j == 2) fs_tx[3] = 1'b0;
         #4;
         check(tx_oe === 1'b1 && pcm_tx === ((j == 1) ? tv[W-1] : tv[W-(j-1)]),
               "R4 short-frame restart", pcm_tx, (j == 1) ? tv[W-1] : tv[W-(j-1)]);
      end
      @(posedge clk); #5;
      check(!tx_oe, "R4 R3 released after restarted slot", tx_oe, 0);

      // R5: long sync held past the slot does not retrigger
      @(posedge clk); #2;
      long_fs = 1'b1;
      tv = 8'h93;
      tx_words[W +: W] = tv;
      fs_tx[1] = 1'b1;
      for (int k = 1; k <= W; k++) begin
         @(posedge clk); #5;
         check(tx_oe === 1'b1 && pcm_tx === tv[W-k], "R5 long-frame bit", pcm_tx, tv[W-k]);
      end
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #5;
         check(!tx_oe, "R5 no retrigger while sync held", tx_oe, 0);
      end
      fs_tx[1] = 1'b0;
      repeat (2) @(posedge clk);

      // R2 R6 R7: sweep all channels in both framing modes
      for (int m = 0; m < 2; m++) begin
         for (int f = 0; f < 32; f++) begin
            for (int ch = 0; ch < N_CH; ch++) begin
               do_slot(ch, 8'(f*53 + ch*29 + 7), 8'(((f*53 + ch*29 + 7) ^ 'h5A) ^ f), m == 1);
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule